// File: doc/BRIEF.md
# Strided Gather Column Address Translator

This block sits on the command path of a memory rank made of several chips that share one command and address bus. For each accepted command it produces a separate column address for every chip. Each lane holds a fixed chip number and forms its address from the shared column address, the request's pattern value and that chip number. The result is that one column command can make every chip read a different column. A group of values spaced at a power-of-two stride can then be collected in one access, as long as the data was written with a matching per-column rotation across chips.

The translation applies only to column reads and writes. All other commands send the shared address to every chip unchanged. All outputs are registered. Every lane updates on the same clock edge, one cycle after the request is accepted. Between requests the outputs keep their last values.

Top module: `strided_col_xlate`

## Requirements
- R1: While rst_ni is low and after its release with no request, every lane strobe is 0, every lane address is 0 and cmd_o is NOP (code 0).
- R2: A request accepted with req_valid_i=1 raises all lane strobes together in the next cycle. A cycle with req_valid_i=0 leaves all strobes at 0 in the next cycle. Back-to-back requests update the lanes on every cycle.
- R3: For READ (code 1) or WRITE (code 2), lane k's address equals req_col_i XOR (req_patt_i zero-extended to the address width, AND k). Lane k occupies bits [k*COL_W +: COL_W] of lane_col_o.
- R4: For any other command code (0, 3 to 7), every lane address equals req_col_i, whatever the pattern.
- R5: Pattern 0 on a read or write gives every lane the unmodified req_col_i, which is a contiguous stride-1 access.
- R6: Lane 0 always receives req_col_i unchanged.
- R7: On a read or write, a lane whose number ANDed with the pattern is zero receives req_col_i unchanged. For example, pattern 4 leaves lanes 0 to 3 unchanged.
- R8: cmd_o carries the accepted command code in the same cycle as the lane strobes.
- R9: Without a request, lane addresses and cmd_o keep their previous values.
- R10: The data layout stores element a*8+w of an 8x8 block at column a, chip w XOR a. With this layout, a READ at column 0 with pattern 1, 3 or 7 gathers the eight elements at stride 2, 4 or 8 from the start of the block. Pattern 0 gathers elements 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request accepted this cycle |
| req_cmd_i | input | 3 | Command code (0 NOP, 1 READ, 2 WRITE, 3 to 7 other) |
| req_col_i | input | COL_W | Shared column address |
| req_patt_i | input | PATT_W | Pattern value |
| lane_stb_o | output | NCHIP | Per-chip command strobe |
| cmd_o | output | 3 | Registered command code |
| lane_col_o | output | NCHIP*COL_W | Per-chip column addresses, lane k at [k*COL_W +: COL_W] |

## Verification
The bench builds the block with its default values: 8 lanes, a 10-bit column address and a 3-bit pattern. With these values every pattern value meets every chip number, so the bench covers all 64 pattern and lane pairs. Addresses up to all-ones show that the XOR reaches only the low three bits and leaves the upper bits alone. The eight lanes also cover a full 8x8 rotated block, which lets the bench check the stride-2, stride-4 and stride-8 gathers against an independent model of the stored data.

// File: rtl/strided_xlate_pkg.sv
package strided_xlate_pkg;
  localparam int CMD_W = 3;
  typedef enum logic [CMD_W-1:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_ACT   = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5
  } cmd_e;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import strided_xlate_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output logic             is_rw_o
);
  always_comb begin
    is_rw_o = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
  end
endmodule

// File: rtl/xlate_lane.sv
module xlate_lane #(
  parameter int COL_W   = 10,
  parameter int PATT_W  = 3,
  parameter int CHIP_ID = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_rw_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [PATT_W-1:0] patt_i,
  output logic              stb_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [COL_W-1:0] ID_EXT = COL_W'(CHIP_ID);

  logic [COL_W-1:0] patt_ext;
  logic [COL_W-1:0] flip;
  logic [COL_W-1:0] col_d;

  always_comb begin
    patt_ext = COL_W'(patt_i);
    flip     = is_rw_i ? (patt_ext & ID_EXT) : '0;
    col_d    = col_i ^ flip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o <= 1'b0;
      col_o <= '0;
    end else begin
      stb_o <= valid_i;
      if (valid_i) col_o <= col_d;
    end
  end

  assert_stb_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> stb_o);
  assert_stb_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !stb_o);
  assert_rw_xlate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_rw_i) |=> ((col_o ^ $past(col_i)) & ~ID_EXT) == '0);
  assert_pass_other_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_rw_i) |=> col_o == $past(col_i));
  assert_patt_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && patt_i == '0) |=> col_o == $past(col_i));
  assert_disjoint_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (COL_W'(patt_i) & ID_EXT) == '0) |=> col_o == $past(col_i));
endmodule

// File: rtl/strided_col_xlate.sv
module strided_col_xlate
  import strided_xlate_pkg::*;
#(
  parameter int NCHIP  = 8,
  parameter int COL_W  = 10,
  parameter int PATT_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [2:0]             req_cmd_i,
  input  logic [COL_W-1:0]       req_col_i,
  input  logic [PATT_W-1:0]      req_patt_i,
  output logic [NCHIP-1:0]       lane_stb_o,
  output logic [2:0]             cmd_o,
  output logic [NCHIP*COL_W-1:0] lane_col_o
);
  localparam int CID_W = (NCHIP > 1) ? $clog2(NCHIP) : 1;

  logic is_rw;

  cmd_classify u_classify (
    .cmd_i   (req_cmd_i),
    .is_rw_o (is_rw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cmd_o <= CMD_NOP;
    else if (req_valid_i) cmd_o <= req_cmd_i;
  end

  for (genvar k = 0; k < NCHIP; k++) begin : g_lane
    xlate_lane #(
      .COL_W   (COL_W),
      .PATT_W  (PATT_W),
      .CHIP_ID (k)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (req_valid_i),
      .is_rw_i (is_rw),
      .col_i   (req_col_i),
      .patt_i  (req_patt_i),
      .stb_o   (lane_stb_o[k]),
      .col_o   (lane_col_o[k*COL_W +: COL_W])
    );
  end

  initial assert (CID_W <= COL_W);

  assert_lane0_plain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> lane_col_o[COL_W-1:0] == $past(req_col_i));
  assert_cmd_echo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> cmd_o == $past(req_cmd_i));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(lane_col_o) && $stable(cmd_o)));
  assert_strobes_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_stb_o == '0) || (lane_stb_o == '1));
endmodule

// File: tb/strided_col_xlate_bench.sv
module strided_col_xlate_bench;
  localparam int NCHIP  = 8;
  localparam int COL_W  = 10;
  localparam int PATT_W = 3;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   req_valid_i = 1'b0;
  logic [2:0]             req_cmd_i = '0;
  logic [COL_W-1:0]       req_col_i = '0;
  logic [PATT_W-1:0]      req_patt_i = '0;
  logic [NCHIP-1:0]       lane_stb_o;
  logic [2:0]             cmd_o;
  logic [NCHIP*COL_W-1:0] lane_col_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strided_col_xlate #(.NCHIP(NCHIP), .COL_W(COL_W), .PATT_W(PATT_W)) u_strided_col_xlate (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i),
    .req_col_i(req_col_i), .req_patt_i(req_patt_i), .lane_stb_o(lane_stb_o),
    .cmd_o(cmd_o), .lane_col_o(lane_col_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] lane(input int k);
    return lane_col_o[k*COL_W +: COL_W];
  endfunction

  // one request, outputs sampled at the following negedge
  task automatic issue(input logic [2:0] c, input logic [COL_W-1:0] a, input logic [PATT_W-1:0] p);
    @(negedge clk);
    req_valid_i = 1'b1; req_cmd_i = c; req_col_i = a; req_patt_i = p;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 stb", 32'(lane_stb_o), 0);
    chk("R1 cmd", 32'(cmd_o), 0);
    chk("R1 col", 32'(lane_col_o == '0), 1);
  endtask

  task automatic t_rw_xlate;
    logic [COL_W-1:0] cols [4] = '{10'h000, 10'h3FF, 10'h155, 10'h2A8};
    for (int i = 0; i < 4; i++)
      for (int p = 0; p < 8; p++) begin
        logic [2:0] c = (p % 2 == 0) ? 3'd1 : 3'd2;
        issue(c, cols[i], PATT_W'(p));
        chk("R2 strobes", 32'(lane_stb_o), 32'hFF);
        chk("R8 cmd", 32'(cmd_o), 32'(c));
        for (int k = 0; k < NCHIP; k++)
          chk("R3 lane", 32'(lane(k)), 32'(cols[i] ^ (COL_W'(p) & COL_W'(k))));
        chk("R6 lane0", 32'(lane(0)), 32'(cols[i]));
      end
  endtask

  task automatic t_other_cmds;
    logic [2:0] codes [6] = '{3'd0, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    for (int i = 0; i < 6; i++) begin
      issue(codes[i], 10'h1C3, 3'd7);
      chk("R8 cmd other", 32'(cmd_o), 32'(codes[i]));
      for (int k = 0; k < NCHIP; k++) chk("R4 passthrough", 32'(lane(k)), 32'h1C3);
    end
  endtask

  task automatic t_patt_zero;
    issue(3'd1, 10'h2F0, 3'd0);
    for (int k = 0; k < NCHIP; k++) chk("R5 pattern zero", 32'(lane(k)), 32'h2F0);
  endtask

  task automatic t_disjoint;
    issue(3'd2, 10'h0A5, 3'd4);
    for (int k = 0; k < 4; k++) chk("R7 pattern 4 low lanes", 32'(lane(k)), 32'h0A5);
    for (int k = 4; k < 8; k++) chk("R7 pattern 4 high lanes", 32'(lane(k)), 32'h0A1);
    issue(3'd1, 10'h3F8, 3'd2);
    chk("R7 pattern 2 lane 5", 32'(lane(5)), 32'h3F8);
    chk("R7 pattern 2 lane 6", 32'(lane(6)), 32'h3FA);
  endtask

  task automatic t_hold;
    logic [NCHIP*COL_W-1:0] snap;
    logic [2:0] csnap;
    issue(3'd1, 10'h111, 3'd5);
    snap = lane_col_o; csnap = cmd_o;
    @(negedge clk);
    req_cmd_i = 3'd2; req_col_i = 10'h3FF; req_patt_i = 3'd7;
    repeat (3) @(negedge clk);
    chk("R2 idle strobes", 32'(lane_stb_o), 0);
    chk("R9 cols held", 32'(lane_col_o == snap), 1);
    chk("R9 cmd held", 32'(cmd_o), 32'(csnap));
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid_i = 1'b1; req_cmd_i = 3'd1; req_col_i = 10'h010; req_patt_i = 3'd3;
    @(negedge clk);
    chk("R2 b2b first", 32'(lane(3)), 32'h013);
    req_cmd_i = 3'd4; req_col_i = 10'h020;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R2 b2b second strobe", 32'(lane_stb_o), 32'hFF);
    chk("R4 b2b second", 32'(lane(3)), 32'h020);
  endtask

  // layout: element a*8+w at column a, chip w^a
  task automatic t_stride;
    int pats [4] = '{0, 1, 3, 7};
    for (int i = 0; i < 4; i++) begin
      int stride = pats[i] + 1;
      logic [7:0] seen = '0;
      int bad = 0;
      issue(3'd1, '0, PATT_W'(pats[i]));
      for (int k = 0; k < NCHIP; k++) begin
        int a = int'(lane(k));
        int v = a * 8 + (k ^ (a & 7));
        if (a > 7 || v % stride != 0 || v / stride > 7) bad++;
        else seen[v / stride] = 1'b1;
      end
      chk($sformatf("R10 stride %0d bad", stride), 32'(bad), 0);
      chk($sformatf("R10 stride %0d cover", stride), 32'(seen), 32'hFF);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_rw_xlate;
    t_other_cmds;
    t_patt_zero;
    t_disjoint;
    t_hold;
    t_back_to_back;
    t_stride;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule